// File: doc/BRIEF.md
# Variable-Resolution Super-Pixel Readout Controller

This block sits between the raster readout of a square image array and the chip's output port. Each incoming pixel is assigned to a region: the whole frame, one of several rectangular windows, or nothing. Inside its region the pixel is folded into a rectangular super-pixel whose width and height are each programmable from 1 to 8. When the last pixel of a super-pixel arrives, the block emits one averaged value, tagged with the super-pixel's top-left coordinate and the region it belongs to. Pixels that belong to no active region produce no output at all.

There are three operating modes. The first uses one block size over the entire frame, from full resolution down to 8x8. The second reads only the programmed windows, each with its own block size. The third combines them: windows keep their own, usually finer, block size and the rest of the frame uses the global size. This gives several high-detail foveae on a coarse background. Up to `NWIN` windows are supported. Each is given by inclusive start and end coordinates. Where windows overlap, the lowest-numbered window owns the pixel. The pixel stream and the result stream each use valid/ready flow control.

Top module: `spx_readout`

## Requirements
- R1: While reset is asserted and just after it is released, `out_valid` is 0 and `in_ready` is 1. The first pixel accepted after reset has coordinate (0,0). Later pixels follow raster order: x increments first, then y.
- R2: With `cfg_mode` = 0 (global mode), every pixel belongs to the global grid. That grid is made of blocks with width `cfg_glb_bw`+1 and height `cfg_glb_bh`+1, with origins at multiples of the block size. Each block yields the truncated integer mean of its pixels, together with its top-left x and y, and `out_win` = `NWIN`. In global mode the window settings are ignored.
- R3: A global block size field of 0/0 gives full resolution: every pixel is output unchanged, at its own coordinate.
- R4: The largest block size, field value 7/7 (8x8 pixels), averages 64 pixels into one output.
- R5: A block cut off by the frame edge or a window edge averages only the pixels inside the region. The divisor is the number of those pixels.
- R6: With `cfg_mode` = 1 (window mode), only pixels inside enabled windows are read. No output is produced for any other pixel, and every output carries the window index 0..`NWIN`-1 in `out_win`.
- R7: Window k spans the inclusive range `cfg_win_x0`..`cfg_win_x1` and `cfg_win_y0`..`cfg_win_y1`, taken from field k (bits k*CW upward). Its block size is field k of `cfg_win_bw`/`cfg_win_bh` (3 bits, size minus one). Its blocks start at the window's start corner.
- R8: A pixel that lies inside several enabled windows belongs to the lowest-numbered one.
- R9: With `cfg_mode` = 2 or 3 (mixed mode), pixels inside enabled windows are handled as in R7 and R8. All other pixels use the global grid of R2 and are tagged `NWIN`.
- R10: A result is emitted in the same clock edge that accepts its closing pixel (bottom-right pixel present in the region). While `out_valid` is 1 and `out_ready` is 0, the output fields hold steady, `in_ready` is 0, and no pixel or result is lost.
- R11: After `ARRAY_DIM`*`ARRAY_DIM` accepted pixels, the raster position wraps to (0,0), and the next frame is processed with no reset in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | 0 global, 1 windows only, 2/3 mixed |
| cfg_glb_bw | input | 3 | Global block width minus one |
| cfg_glb_bh | input | 3 | Global block height minus one |
| cfg_win_en | input | NWIN | Window enables |
| cfg_win_x0 | input | NWIN*CW | Window start columns |
| cfg_win_y0 | input | NWIN*CW | Window start rows |
| cfg_win_x1 | input | NWIN*CW | Window end columns (inclusive) |
| cfg_win_y1 | input | NWIN*CW | Window end rows (inclusive) |
| cfg_win_bw | input | NWIN*3 | Window block widths minus one |
| cfg_win_bh | input | NWIN*3 | Window block heights minus one |
| in_valid | input | 1 | Pixel present |
| in_ready | output | 1 | Pixel accepted when high with in_valid |
| in_pix | input | PIX_W | Pixel value |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_val | output | PIX_W | Averaged super-pixel value |
| out_x | output | CW | Top-left column of the super-pixel |
| out_y | output | CW | Top-left row of the super-pixel |
| out_win | output | TW | Window index, or NWIN for the global grid |

## Verification
The assertions on result tags assume that `cfg_mode` does not change while a result is pending. The bench therefore reprograms the configuration only after a frame has been fully drained. The assertions on holding and back-pressure assume nothing about the pixel source. The stimulus still throttles `in_valid` and `out_ready` in independent cycles, so that stalls hit both when a block closes and when a pixel is merely being accumulated. Window layouts keep every edge on the block grid of the region underneath, so that every super-pixel's closing pixel stays with its owner. This also holds for the fully overlapping windows in the priority test.

// File: rtl/spx_pkg.sv
package spx_pkg;
  localparam int BLK_FW = 3;          // block size field width (size - 1)
  localparam int CNT_W  = 7;          // pixel count, up to 64

  typedef enum logic [1:0] {
    MODE_GLOBAL = 2'd0,
    MODE_WINDOW = 2'd1,
    MODE_MIX_A  = 2'd2,
    MODE_MIX_B  = 2'd3
  } mode_e;
endpackage

// File: rtl/spx_owner.sv
module spx_owner
  import spx_pkg::*;
#(
  parameter int N    = 512,
  parameter int NWIN = 4,
  parameter int CW   = $clog2(N),
  parameter int TW   = $clog2(NWIN + 1)
) (
  input  logic [CW-1:0]          x,
  input  logic [CW-1:0]          y,
  input  logic [1:0]             mode,
  input  logic [BLK_FW-1:0]      glb_bw,
  input  logic [BLK_FW-1:0]      glb_bh,
  input  logic [NWIN-1:0]        win_en,
  input  logic [NWIN*CW-1:0]     win_x0,
  input  logic [NWIN*CW-1:0]     win_y0,
  input  logic [NWIN*CW-1:0]     win_x1,
  input  logic [NWIN*CW-1:0]     win_y1,
  input  logic [NWIN*BLK_FW-1:0] win_bw,
  input  logic [NWIN*BLK_FW-1:0] win_bh,
  output logic                   take,
  output logic [TW-1:0]          tag,
  output logic [CW-1:0]          bx,
  output logic [CW-1:0]          by,
  output logic                   first,
  output logic                   close
);
  localparam int XW = CW + 1;

  logic [NWIN-1:0] hit;
  logic            found, use_win, use_glb;
  int              sel;
  mode_e           md;
  logic [CW-1:0]   sx, sy, ex, ey, dx, dy, bwc, bhc;
  logic [XW-1:0]   endx, endy;

  for (genvar k = 0; k < NWIN; k++) begin : g_hit
    assign hit[k] = win_en[k]
                 && (x >= win_x0[k*CW +: CW]) && (x <= win_x1[k*CW +: CW])
                 && (y >= win_y0[k*CW +: CW]) && (y <= win_y1[k*CW +: CW]);
  end

  // lowest index wins
  always_comb begin
    found = 1'b0;
    sel   = 0;
    for (int k = NWIN - 1; k >= 0; k--) begin
      if (hit[k]) begin
        found = 1'b1;
        sel   = k;
      end
    end
  end

  always_comb begin
    md      = mode_e'(mode);
    use_win = found && (md != MODE_GLOBAL);
    use_glb = (md == MODE_GLOBAL) || (!found && (md != MODE_WINDOW));
    take    = use_win || use_glb;
    if (use_win) begin
      sx  = win_x0[sel*CW +: CW];
      sy  = win_y0[sel*CW +: CW];
      ex  = win_x1[sel*CW +: CW];
      ey  = win_y1[sel*CW +: CW];
      bwc = CW'(win_bw[sel*BLK_FW +: BLK_FW]) + CW'(1);
      bhc = CW'(win_bh[sel*BLK_FW +: BLK_FW]) + CW'(1);
      tag = TW'(sel);
    end else begin
      sx  = '0;
      sy  = '0;
      ex  = CW'(N - 1);
      ey  = CW'(N - 1);
      bwc = CW'(glb_bw) + CW'(1);
      bhc = CW'(glb_bh) + CW'(1);
      tag = TW'(NWIN);
    end
    dx    = x - sx;
    dy    = y - sy;
    bx    = sx + (dx / bwc) * bwc;
    by    = sy + (dy / bhc) * bhc;
    endx  = {1'b0, bx} + XW'(bwc) - XW'(1);
    endy  = {1'b0, by} + XW'(bhc) - XW'(1);
    first = (x == bx) && (y == by);
    close = (({1'b0, x} == endx) || (x == ex)) && (({1'b0, y} == endy) || (y == ey));
  end
endmodule

// File: rtl/spx_accum.sv
module spx_accum
  import spx_pkg::*;
#(
  parameter int N     = 512,
  parameter int CW    = $clog2(N),
  parameter int PIX_W = 8,
  parameter int SUM_W = PIX_W + 6
) (
  input  logic             clk,
  input  logic             en,
  input  logic [CW-1:0]    col,
  input  logic             fresh,
  input  logic [PIX_W-1:0] pix,
  output logic [SUM_W-1:0] sum_nx,
  output logic [CNT_W-1:0] cnt_nx
);
  logic [SUM_W-1:0] sum_q [N];
  logic [CNT_W-1:0] cnt_q [N];

  always_comb begin
    if (fresh) begin
      sum_nx = SUM_W'(pix);
      cnt_nx = CNT_W'(1);
    end else begin
      sum_nx = sum_q[col] + SUM_W'(pix);
      cnt_nx = cnt_q[col] + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      sum_q[col] <= sum_nx;
      cnt_q[col] <= cnt_nx;
    end
  end
endmodule

// File: rtl/spx_readout.sv
module spx_readout
  import spx_pkg::*;
#(
  parameter int ARRAY_DIM = 512,
  parameter int NWIN      = 4,
  parameter int PIX_W     = 8,
  parameter int CW        = $clog2(ARRAY_DIM),
  parameter int TW        = $clog2(NWIN + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             cfg_mode,
  input  logic [BLK_FW-1:0]      cfg_glb_bw,
  input  logic [BLK_FW-1:0]      cfg_glb_bh,
  input  logic [NWIN-1:0]        cfg_win_en,
  input  logic [NWIN*CW-1:0]     cfg_win_x0,
  input  logic [NWIN*CW-1:0]     cfg_win_y0,
  input  logic [NWIN*CW-1:0]     cfg_win_x1,
  input  logic [NWIN*CW-1:0]     cfg_win_y1,
  input  logic [NWIN*BLK_FW-1:0] cfg_win_bw,
  input  logic [NWIN*BLK_FW-1:0] cfg_win_bh,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [PIX_W-1:0]       in_pix,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [PIX_W-1:0]       out_val,
  output logic [CW-1:0]          out_x,
  output logic [CW-1:0]          out_y,
  output logic [TW-1:0]          out_win
);
  localparam int SUM_W = PIX_W + 6;

  logic [CW-1:0]    px_q, py_q, px_d, py_d;
  logic             vld_d, accept, emit;
  logic             take, first, close;
  logic [TW-1:0]    tag;
  logic [CW-1:0]    bx, by;
  logic [SUM_W-1:0] sum_nx, mean;
  logic [CNT_W-1:0] cnt_nx;

  spx_owner #(.N(ARRAY_DIM), .NWIN(NWIN), .CW(CW), .TW(TW)) u_owner (
    .x(px_q), .y(py_q), .mode(cfg_mode),
    .glb_bw(cfg_glb_bw), .glb_bh(cfg_glb_bh), .win_en(cfg_win_en),
    .win_x0(cfg_win_x0), .win_y0(cfg_win_y0),
    .win_x1(cfg_win_x1), .win_y1(cfg_win_y1),
    .win_bw(cfg_win_bw), .win_bh(cfg_win_bh),
    .take(take), .tag(tag), .bx(bx), .by(by), .first(first), .close(close)
  );

  spx_accum #(.N(ARRAY_DIM), .CW(CW), .PIX_W(PIX_W), .SUM_W(SUM_W)) u_accum (
    .clk(clk), .en(accept && take), .col(bx), .fresh(first), .pix(in_pix),
    .sum_nx(sum_nx), .cnt_nx(cnt_nx)
  );

  // next state
  always_comb begin
    in_ready = !out_valid || out_ready;
    accept   = in_valid && in_ready;
    emit     = accept && take && close;
    mean     = sum_nx / SUM_W'(cnt_nx);
    px_d     = px_q;
    py_d     = py_q;
    if (accept) begin
      if (px_q == CW'(ARRAY_DIM - 1)) begin
        px_d = '0;
        py_d = (py_q == CW'(ARRAY_DIM - 1)) ? '0 : py_q + CW'(1);
      end else begin
        px_d = px_q + CW'(1);
      end
    end
    if (emit)           vld_d = 1'b1;
    else if (out_ready) vld_d = 1'b0;
    else                vld_d = out_valid;
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      px_q      <= '0;
      py_q      <= '0;
      out_valid <= 1'b0;
    end else begin
      px_q      <= px_d;
      py_q      <= py_d;
      out_valid <= vld_d;
    end
  end

  // result payload, enabled load
  always_ff @(posedge clk) begin
    if (emit) begin
      out_val <= PIX_W'(mean);
      out_x   <= bx;
      out_y   <= by;
      out_win <= tag;
    end
  end
endmodule

// File: rtl/spx_readout_chk.sv
module spx_readout_chk #(
  parameter int NWIN  = 4,
  parameter int PIX_W = 8,
  parameter int CW    = 9,
  parameter int TW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cfg_mode,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PIX_W-1:0] out_val,
  input logic [CW-1:0]    out_x,
  input logic [CW-1:0]    out_y,
  input logic [TW-1:0]    out_win
);
  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_val) && $stable(out_x)
                                && $stable(out_y) && $stable(out_win));
  // R10
  backpress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  // R1
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
  // R2
  global_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cfg_mode == 2'd0 |-> out_win == TW'(NWIN));
  // R6
  window_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cfg_mode == 2'd1 |-> out_win < TW'(NWIN));
endmodule

bind spx_readout spx_readout_chk #(.NWIN(NWIN), .PIX_W(PIX_W), .CW(CW), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_val(out_val),
  .out_x(out_x), .out_y(out_y), .out_win(out_win)
);

// File: tb/spx_readout_tb.sv
module spx_readout_tb;
  localparam int N    = 16;
  localparam int NWIN = 4;
  localparam int PW   = 8;
  localparam int CW   = 4;
  localparam int TW   = 3;

  logic clk, rst_n;
  logic [1:0] cfg_mode;
  logic [2:0] cfg_glb_bw, cfg_glb_bh;
  logic [NWIN-1:0] cfg_win_en;
  logic [NWIN*CW-1:0] cfg_win_x0, cfg_win_y0, cfg_win_x1, cfg_win_y1;
  logic [NWIN*3-1:0] cfg_win_bw, cfg_win_bh;
  logic in_valid, in_ready, out_valid, out_ready;
  logic [PW-1:0] in_pix, out_val;
  logic [CW-1:0] out_x, out_y;
  logic [TW-1:0] out_win;

  int n_chk = 0, n_fail = 0;
  bit timeout = 0;
  int mode, gbw, gbh;
  int wen[NWIN], wx0[NWIN], wy0[NWIN], wx1[NWIN], wy1[NWIN], wbw[NWIN], wbh[NWIN];
  int ev[N*N], ex[N*N], ey[N*N], ew[N*N];
  int nexp;

  spx_readout #(.ARRAY_DIM(N), .NWIN(NWIN), .PIX_W(PW)) u_dut (.*);

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string msg);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  function automatic int pix(int seed, int x, int y);
    return (x * 7 + y * 13 + seed * 29 + x * y) % 256;
  endfunction

  function automatic int owner(int x, int y);
    int f = -1;
    for (int k = NWIN - 1; k >= 0; k--)
      if (wen[k] != 0 && x >= wx0[k] && x <= wx1[k] && y >= wy0[k] && y <= wy1[k]) f = k;
    if (mode == 0) return NWIN;
    if (f >= 0) return f;
    if (mode == 1) return -1;
    return NWIN;
  endfunction

  task automatic apply_cfg();
    @(negedge clk);
    cfg_mode = 2'(mode); cfg_glb_bw = 3'(gbw); cfg_glb_bh = 3'(gbh);
    for (int k = 0; k < NWIN; k++) begin
      cfg_win_en[k] = (wen[k] != 0);
      cfg_win_x0[k*CW +: CW] = CW'(wx0[k]); cfg_win_y0[k*CW +: CW] = CW'(wy0[k]);
      cfg_win_x1[k*CW +: CW] = CW'(wx1[k]); cfg_win_y1[k*CW +: CW] = CW'(wy1[k]);
      cfg_win_bw[k*3 +: 3] = 3'(wbw[k]); cfg_win_bh[k*3 +: 3] = 3'(wbh[k]);
    end
  endtask

  task automatic clear_win();
    for (int k = 0; k < NWIN; k++) begin
      wen[k] = 0; wx0[k] = 0; wy0[k] = 0; wx1[k] = 0; wy1[k] = 0; wbw[k] = 0; wbh[k] = 0;
    end
  endtask

  // expected results from the requirements, in closing-pixel order
  task automatic build_exp(input int seed);
    int o, sx, sy, exx, eyy, bw, bh, bx, by, xe, ye, s, c;
    nexp = 0;
    for (int y = 0; y < N; y++) begin
      for (int x = 0; x < N; x++) begin
        o = owner(x, y);
        if (o >= 0) begin
          if (o == NWIN) begin
            sx = 0; sy = 0; exx = N - 1; eyy = N - 1; bw = gbw + 1; bh = gbh + 1;
          end else begin
            sx = wx0[o]; sy = wy0[o]; exx = wx1[o]; eyy = wy1[o]; bw = wbw[o] + 1; bh = wbh[o] + 1;
          end
          bx = sx + ((x - sx) / bw) * bw;
          by = sy + ((y - sy) / bh) * bh;
          xe = (bx + bw - 1 < exx) ? bx + bw - 1 : exx;
          ye = (by + bh - 1 < eyy) ? by + bh - 1 : eyy;
          if (x == xe && y == ye) begin
            s = 0; c = 0;
            for (int yy = by; yy <= ye; yy++)
              for (int xx = bx; xx <= xe; xx++)
                if (owner(xx, yy) == o) begin s += pix(seed, xx, yy); c++; end
            ev[nexp] = s / c; ex[nexp] = bx; ey[nexp] = by; ew[nexp] = o;
            nexp++;
          end
        end
      end
    end
  endtask

  task automatic run_frame(input int seed, input bit stall, input string req);
    int pi = 0, oi = 0, cyc = 0;
    bit held = 0;
    logic [PW-1:0] hv;
    logic [CW-1:0] hx, hy;
    build_exp(seed);
    while ((pi < N * N || oi < nexp || out_valid) && !timeout) begin
      @(negedge clk);
      cyc++;
      if (held)
        chk(out_valid && out_val == hv && out_x == hx && out_y == hy, "R10",
            $sformatf("held result changed: val %0d x %0d y %0d exp %0d %0d %0d",
                      out_val, out_x, out_y, hv, hx, hy));
      in_valid  = (pi < N * N) && (!stall || (cyc % 3) != 0);
      in_pix    = PW'(pix(seed, pi % N, pi / N));
      out_ready = !stall || (cyc % 4) >= 2;
      #1;
      if (out_valid && out_ready) begin
        if (oi < nexp)
          chk(out_val == PW'(ev[oi]) && out_x == CW'(ex[oi]) && out_y == CW'(ey[oi])
              && out_win == TW'(ew[oi]), req,
              $sformatf("result %0d: val %0d x %0d y %0d win %0d exp %0d %0d %0d %0d",
                        oi, out_val, out_x, out_y, out_win, ev[oi], ex[oi], ey[oi], ew[oi]));
        else
          chk(0, req, $sformatf("extra result x %0d y %0d win %0d exp none", out_x, out_y, out_win));
        oi++;
      end
      if (stall && out_valid && !out_ready)
        chk(!in_ready, "R10", $sformatf("in_ready %0d while stalled exp 0", in_ready));
      held = out_valid && !out_ready;
      hv = out_val; hx = out_x; hy = out_y;
      if (in_valid && in_ready) pi++;
      if (cyc > 20000) begin
        timeout = 1;
        chk(0, req, "watchdog expired");
      end
    end
    @(negedge clk);
    in_valid = 0; out_ready = 1;
    chk(oi == nexp, req, $sformatf("result count %0d exp %0d", oi, nexp));
  endtask

  task automatic t_reset();
    #1;
    chk(out_valid == 0 && in_ready == 1, "R1",
        $sformatf("reset out_valid %0d in_ready %0d exp 0 1", out_valid, in_ready));
  endtask

  task automatic t_full_res();   // R1 R3
    clear_win(); mode = 0; gbw = 0; gbh = 0;
    wen[0] = 1; wx1[0] = 5; wy1[0] = 5; wbw[0] = 3; // ignored in global mode (R2)
    apply_cfg();
    run_frame(1, 0, "R3");
  endtask

  task automatic t_global_2x2(); clear_win(); mode = 0; gbw = 1; gbh = 1; apply_cfg(); run_frame(2, 0, "R2"); endtask
  task automatic t_global_8x8(); clear_win(); mode = 0; gbw = 7; gbh = 7; apply_cfg(); run_frame(3, 0, "R4"); endtask
  task automatic t_edge_3x5();   clear_win(); mode = 0; gbw = 2; gbh = 4; apply_cfg(); run_frame(4, 0, "R5"); endtask

  task automatic t_windows();    // R6 R7 R5
    clear_win(); mode = 1; gbw = 1; gbh = 1;
    wen[0] = 1; wx0[0] = 2;  wy0[0] = 1;  wx1[0] = 8;  wy1[0] = 5;  wbw[0] = 1; wbh[0] = 2;
    wen[1] = 1; wx0[1] = 11; wy0[1] = 10; wx1[1] = 14; wy1[1] = 13;
    wen[3] = 1; wx0[3] = 0;  wy0[3] = 14; wx1[3] = 1;  wy1[3] = 15; wbw[3] = 3; wbh[3] = 3;
    apply_cfg();
    run_frame(5, 0, "R6_R7");
  endtask

  task automatic t_priority();   // R8
    clear_win(); mode = 1;
    wen[0] = 1; wx0[0] = 4; wy0[0] = 4; wx1[0] = 7; wy1[0] = 7; wbw[0] = 1; wbh[0] = 1;
    wen[1] = 1; wx0[1] = 4; wy0[1] = 4; wx1[1] = 7; wy1[1] = 7; wbw[1] = 3; wbh[1] = 3;
    apply_cfg();
    run_frame(6, 0, "R8");
  endtask

  task automatic t_mixed();      // R9
    clear_win(); mode = 2; gbw = 3; gbh = 3;
    wen[0] = 1; wx0[0] = 4;  wy0[0] = 8; wx1[0] = 7;  wy1[0] = 11;
    wen[2] = 1; wx0[2] = 12; wy0[2] = 0; wx1[2] = 15; wy1[2] = 3; wbw[2] = 1; wbh[2] = 1;
    apply_cfg();
    run_frame(7, 0, "R9");
  endtask

  task automatic t_stall();      // R10
    clear_win(); mode = 0; gbw = 1; gbh = 0; apply_cfg();
    run_frame(8, 1, "R10");
  endtask

  task automatic t_wrap();       // R11: frames back to back, raster restarts
    clear_win(); mode = 0; gbw = 3; gbh = 1; apply_cfg();
    run_frame(9, 0, "R11");
    run_frame(10, 0, "R11");
  endtask

  initial begin
    rst_n = 0; in_valid = 0; in_pix = '0; out_ready = 1;
    clear_win(); mode = 0; gbw = 0; gbh = 0;
    cfg_mode = '0; cfg_glb_bw = '0; cfg_glb_bh = '0; cfg_win_en = '0;
    cfg_win_x0 = '0; cfg_win_y0 = '0; cfg_win_x1 = '0; cfg_win_y1 = '0;
    cfg_win_bw = '0; cfg_win_bh = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_full_res();
    t_global_2x2();
    t_global_8x8();
    t_edge_3x5();
    t_windows();
    t_priority();
    t_mixed();
    t_stall();
    t_wrap();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule